// File: doc/BRIEF.md
# FIR peak-finding bunch-crossing identifier

This block takes one digitised trigger-tower sample per bunch crossing, with the clock running at the crossing rate. It passes the samples through a short FIR filter whose coefficients can be programmed. It assigns each energy deposit to exactly one crossing, the one where the filter output reaches a local maximum. The filter value at that crossing has a programmable pedestal subtracted and a noise threshold applied. The result is then scaled by a right shift and turned into an 8-bit transverse-energy code by a programmable lookup table.

The block produces one energy word per crossing. It also gives a strobe that marks the crossings identified as peaks. Because a peak is never followed by another peak, a reported crossing is always followed by a zero crossing. A downstream pairing multiplexer relies on that gap. One instance serves one channel, and a module handling several towers places one instance per channel.

Top module: `bcid_peak_top`

## Requirements
- R1: After reset, `peak_o` and `energy_o` are 0. All filter coefficients and all lookup-table entries are 0, so a peak found before any table load reports energy 0.
- R2: The filter output for crossing n is y(n) = c0*s(n) + c1*s(n-1) + c2*s(n-2) + c3*s(n-3) + c4*s(n-4). Coefficient ck is applied to the sample k crossings old, and s(n) is taken as 0 before the first sample. Coefficient k is loaded in one cycle with `coef_we_i`=1 and `coef_sel_i`=k.
- R3: Crossing n is a peak candidate when y(n-1) < y(n) and y(n) >= y(n+1). On a flat top, only the first crossing of the flat run qualifies.
- R4: The result for the crossing whose sample is captured at clock edge t is on `peak_o`/`energy_o` after edge t+4.
- R5: `peak_o` is never high in two consecutive cycles.
- R6: `energy_o` is 0 in every cycle where `peak_o` is 0.
- R7: Let p = y(n) - `pedestal_i` when y(n) > `pedestal_i`, and p = 0 otherwise. A peak candidate is reported on `peak_o` only when p >= `noise_cut_i`.
- R8: For a reported crossing, the table index is p >> `shift_i`, clamped to 63. `energy_o` is the table entry at that index. Entry a is written in one cycle with `lut_we_i`=1, `lut_addr_i`=a and the value on `lut_data_i`.
- R9: A coefficient write with `coef_sel_i` of 5, 6 or 7 changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 10 | Digitised sample for the current crossing |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_sel_i | input | 3 | Tap number of the coefficient to write |
| coef_i | input | 4 | Unsigned coefficient value |
| lut_we_i | input | 1 | Lookup-table write strobe |
| lut_addr_i | input | 6 | Table entry to write |
| lut_data_i | input | 8 | Energy code to store |
| pedestal_i | input | 17 | Pedestal subtracted from the filter output |
| noise_cut_i | input | 17 | Minimum pedestal-corrected value for a report |
| shift_i | input | 4 | Right shift applied before lookup |
| peak_o | output | 1 | Strobe marking an identified crossing |
| energy_o | output | 8 | Energy code, zero except on identified crossings |

## Verification
Four properties are checked on every cycle:
- the strobe never repeats in adjacent cycles;
- no energy appears without the strobe;
- each strobe lines up with a strict rise followed by a non-rise in the registered filter output, three and four cycles earlier;
- each reported value clears the pedestal and noise cut.

Other behaviour is shown only by the bench's scenarios:
- the filter arithmetic and tap ordering;
- the exact four-cycle latency;
- the choice of the first crossing on a flat top;
- the clamping of the table index at its top entry;
- table contents;
- ignored out-of-range coefficient writes.

In those scenarios, a reference model follows every crossing.

// File: rtl/bcid_pkg.sv
package bcid_pkg;
  localparam int unsigned PIPE_LAT = 4;

  function automatic int unsigned acc_width(int unsigned sw, int unsigned cw, int unsigned nt);
    return sw + cw + $clog2(nt);
  endfunction
endpackage

// File: rtl/bcid_fir.sv
module bcid_fir #(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 4,
  parameter int N_TAPS   = 5,
  parameter int SUM_W    = 17,
  parameter int SEL_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                coef_we_i,
  input  logic [SEL_W-1:0]    coef_sel_i,
  input  logic [COEF_W-1:0]   coef_i,
  output logic [SUM_W-1:0]    y_o
);
  logic [SAMPLE_W-1:0] tap_q  [N_TAPS];
  logic [COEF_W-1:0]   coef_q [N_TAPS];
  logic [SUM_W-1:0]    prod   [N_TAPS];
  logic [SUM_W-1:0]    acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_TAPS; k++) begin
        tap_q[k]  <= '0;
        coef_q[k] <= '0;
      end
    end else begin
      tap_q[0] <= sample_i;
      for (int k = 1; k < N_TAPS; k++) tap_q[k] <= tap_q[k-1];
      // out-of-range selects are dropped
      if (coef_we_i && (int'(coef_sel_i) < N_TAPS)) coef_q[coef_sel_i] <= coef_i;
    end
  end

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    assign prod[k] = SUM_W'(tap_q[k]) * SUM_W'(coef_q[k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < N_TAPS; k++) acc = acc + prod[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_o <= '0;
    else         y_o <= acc;
  end
endmodule

// File: rtl/bcid_peak.sv
module bcid_peak #(
  parameter int SUM_W   = 17,
  parameter int SHIFT_W = 4,
  parameter int LUT_AW  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SUM_W-1:0]   y_i,
  input  logic [SUM_W-1:0]   pedestal_i,
  input  logic [SUM_W-1:0]   noise_cut_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               hit_o,
  output logic [LUT_AW-1:0]  idx_o
);
  localparam logic [SUM_W-1:0] IDX_MAX = SUM_W'((1 << LUT_AW) - 1);

  logic [SUM_W-1:0]  y1_q, y2_q;
  logic [SUM_W-1:0]  net, scaled;
  logic              is_peak, above;
  logic [LUT_AW-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y1_q <= '0;
      y2_q <= '0;
    end else begin
      y1_q <= y_i;
      y2_q <= y1_q;
    end
  end

  // y1_q is the centre crossing; ties resolve to the earlier one
  always_comb begin
    is_peak = (y2_q < y1_q) && (y1_q >= y_i);
    net     = (y1_q > pedestal_i) ? (y1_q - pedestal_i) : '0;
    above   = (net >= noise_cut_i);
    scaled  = net >> shift_i;
    idx     = (scaled > IDX_MAX) ? IDX_MAX[LUT_AW-1:0] : scaled[LUT_AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0;
      idx_o <= '0;
    end else begin
      hit_o <= is_peak && above;
      idx_o <= idx;
    end
  end
endmodule

// File: rtl/bcid_lut.sv
module bcid_lut #(
  parameter int LUT_AW = 6,
  parameter int E_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LUT_AW-1:0] waddr_i,
  input  logic [E_W-1:0]    wdata_i,
  input  logic              hit_i,
  input  logic [LUT_AW-1:0] idx_i,
  output logic              peak_o,
  output logic [E_W-1:0]    energy_o
);
  localparam int DEPTH = 1 << LUT_AW;

  logic [E_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_o   <= 1'b0;
      energy_o <= '0;
    end else begin
      peak_o   <= hit_i;
      energy_o <= hit_i ? mem_q[idx_i] : '0;
    end
  end
endmodule

// File: rtl/bcid_peak_top.sv
module bcid_peak_top #(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 4,
  parameter int N_TAPS   = 5,
  parameter int LUT_AW   = 6,
  parameter int E_W      = 8,
  parameter int SHIFT_W  = 4,
  localparam int SUM_W   = int'(bcid_pkg::acc_width(SAMPLE_W, COEF_W, N_TAPS)),
  localparam int SEL_W   = $clog2(N_TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                coef_we_i,
  input  logic [SEL_W-1:0]    coef_sel_i,
  input  logic [COEF_W-1:0]   coef_i,
  input  logic                lut_we_i,
  input  logic [LUT_AW-1:0]   lut_addr_i,
  input  logic [E_W-1:0]      lut_data_i,
  input  logic [SUM_W-1:0]    pedestal_i,
  input  logic [SUM_W-1:0]    noise_cut_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic                peak_o,
  output logic [E_W-1:0]      energy_o
);
  logic [SUM_W-1:0]  fir_y;
  logic              hit;
  logic [LUT_AW-1:0] idx;

  bcid_fir #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .N_TAPS(N_TAPS), .SUM_W(SUM_W), .SEL_W(SEL_W)
  ) u_fir (
    .clk_i, .rst_ni, .sample_i, .coef_we_i, .coef_sel_i, .coef_i, .y_o(fir_y)
  );

  bcid_peak #(
    .SUM_W(SUM_W), .SHIFT_W(SHIFT_W), .LUT_AW(LUT_AW)
  ) u_peak (
    .clk_i, .rst_ni, .y_i(fir_y), .pedestal_i, .noise_cut_i, .shift_i,
    .hit_o(hit), .idx_o(idx)
  );

  bcid_lut #(
    .LUT_AW(LUT_AW), .E_W(E_W)
  ) u_lut (
    .clk_i, .rst_ni, .we_i(lut_we_i), .waddr_i(lut_addr_i), .wdata_i(lut_data_i),
    .hit_i(hit), .idx_i(idx), .peak_o, .energy_o
  );
endmodule

// File: rtl/bcid_peak_chk.sv
module bcid_peak_chk #(
  parameter int SUM_W = 17,
  parameter int E_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SUM_W-1:0] fir_y_i,
  input logic [SUM_W-1:0] pedestal_i,
  input logic [SUM_W-1:0] noise_cut_i,
  input logic             peak_i,
  input logic [E_W-1:0]   energy_i
);
  logic [SUM_W-1:0] yh1, yh2, yh3, yh4, ph1, ph2, ch1, ch2;
  logic [2:0]       cyc_q;
  logic             armed;
  logic [SUM_W-1:0] net_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      yh1 <= '0; yh2 <= '0; yh3 <= '0; yh4 <= '0;
      ph1 <= '0; ph2 <= '0; ch1 <= '0; ch2 <= '0;
      cyc_q <= '0;
    end else begin
      yh1 <= fir_y_i; yh2 <= yh1; yh3 <= yh2; yh4 <= yh3;
      ph1 <= pedestal_i; ph2 <= ph1;
      ch1 <= noise_cut_i; ch2 <= ch1;
      if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
    end
  end

  assign armed = (cyc_q >= 3'd5);
  assign net_h = (yh3 > ph2) ? (yh3 - ph2) : '0;

  a_r5_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_i |=> !peak_i);

  a_r6_zero_off_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak_i |-> (energy_i == '0));

  a_r3_local_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && peak_i) |-> ((yh3 > yh4) && (yh3 >= yh2)));

  a_r7_noise_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && peak_i) |-> (net_h >= ch2));
endmodule

bind bcid_peak_top bcid_peak_chk #(.SUM_W(SUM_W), .E_W(E_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fir_y_i(fir_y), .pedestal_i(pedestal_i),
  .noise_cut_i(noise_cut_i), .peak_i(peak_o), .energy_i(energy_o)
);

// File: tb/sim_bcid_peak_top.sv
module sim_bcid_peak_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  sample = '0;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_sel = '0;
  logic [3:0]  coef = '0;
  logic        lut_we = 1'b0;
  logic [5:0]  lut_addr = '0;
  logic [7:0]  lut_data = '0;
  logic [16:0] ped = '0;
  logic [16:0] cut = '0;
  logic [3:0]  shift = '0;
  logic        peak;
  logic [7:0]  energy;

  int n_chk = 0;
  int n_fail = 0;
  int c_m [5];
  int lut_m [64];
  int stim [40];
  int stim_n = 0;

  always #4 clk = ~clk;

  bcid_peak_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .coef_we_i(coef_we),
    .coef_sel_i(coef_sel), .coef_i(coef), .lut_we_i(lut_we), .lut_addr_i(lut_addr),
    .lut_data_i(lut_data), .pedestal_i(ped), .noise_cut_i(cut), .shift_i(shift),
    .peak_o(peak), .energy_o(energy)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_coef(input int k, input int v);
    coef_we = 1'b1; coef_sel = 3'(k); coef = 4'(v);
    tick();
    coef_we = 1'b0;
    if (k < 5) c_m[k] = v;
  endtask

  task automatic set_coefs(input int a, input int b, input int c, input int d, input int e);
    set_coef(0, a); set_coef(1, b); set_coef(2, c); set_coef(3, d); set_coef(4, e);
  endtask

  task automatic set_lut(input int a, input int v);
    lut_we = 1'b1; lut_addr = 6'(a); lut_data = 8'(v);
    tick();
    lut_we = 1'b0;
    lut_m[a] = v;
  endtask

  task automatic flush();
    sample = '0;
    repeat (8) tick();
  endtask

  function automatic int s_at(input int m);
    if (m < 0 || m >= stim_n) return 0;
    return stim[m];
  endfunction

  function automatic int y_at(input int m);
    int acc = 0;
    for (int k = 0; k < 5; k++) acc += c_m[k] * s_at(m - k);
    return acc;
  endfunction

  // expected {peak,energy} packed as peak*256+energy
  function automatic int expect_at(input int m);
    int y, p, idx;
    bit pk;
    y   = y_at(m);
    pk  = (y_at(m - 1) < y) && (y >= y_at(m + 1));
    p   = (y > int'(ped)) ? y - int'(ped) : 0;
    if (!(pk && p >= int'(cut))) return 0;
    idx = p >>> int'(shift);
    if (idx > 63) idx = 63;
    return 256 + lut_m[idx];
  endfunction

  // streams stim[], checks every crossing against the model
  task automatic run_stream(input string req);
    int total;
    bit prev;
    total = stim_n + 6;
    prev = 1'b0;
    for (int i = 0; i < total + 4; i++) begin
      sample = 10'(s_at(i));
      tick();
      if (i >= 4) begin
        check((int'(peak) * 256 + int'(energy)) == expect_at(i - 4), req,
              $sformatf("crossing %0d {peak,energy}", i - 4),
              int'(peak) * 256 + int'(energy), expect_at(i - 4));
        if (prev && peak) check(1'b0, "R5", "consecutive peak", 1, 0);
        prev = peak;
      end
    end
    sample = '0;
  endtask

  task automatic t_reset();
    check(peak == 1'b0, "R1", "peak_o after reset", int'(peak), 0);
    check(energy == 8'd0, "R1", "energy_o after reset", int'(energy), 0);
    set_coefs(1, 2, 3, 2, 1);
    flush();
    stim_n = 4; stim[0] = 0; stim[1] = 50; stim[2] = 100; stim[3] = 50;
    run_stream("R1");
  endtask

  task automatic t_lut_load();
    for (int a = 0; a < 64; a++) set_lut(a, (a * 4 + 3) & 255);
    shift = 4'd4;
    flush();
    stim_n = 4; stim[0] = 20; stim[1] = 100; stim[2] = 60; stim[3] = 10;
    run_stream("R8");
  endtask

  task automatic t_filter_shape();
    set_coefs(2, 3, 1, 0, 1);
    shift = 4'd3;
    flush();
    stim_n = 6; stim[0] = 7; stim[1] = 90; stim[2] = 15; stim[3] = 0; stim[4] = 40; stim[5] = 3;
    run_stream("R2");
  endtask

  task automatic t_two_pulses();
    set_coefs(1, 2, 3, 2, 1);
    shift = 4'd4;
    flush();
    stim_n = 12;
    for (int i = 0; i < 12; i++) stim[i] = 0;
    stim[1] = 80; stim[8] = 90; stim[9] = 30;
    run_stream("R3");
  endtask

  task automatic t_plateau();
    set_coefs(1, 0, 0, 0, 0);
    shift = 4'd2;
    flush();
    stim_n = 8;
    stim[0] = 5; stim[1] = 30; stim[2] = 30; stim[3] = 10;
    stim[4] = 40; stim[5] = 40; stim[6] = 40; stim[7] = 0;
    run_stream("R3");
  endtask

  task automatic t_alternate();
    flush();
    stim_n = 8;
    for (int i = 0; i < 8; i++) stim[i] = (i % 2) ? 50 : 0;
    run_stream("R5");
  endtask

  task automatic t_ped_cut();
    ped = 17'd20; cut = 17'd10; shift = 4'd0;
    flush();
    stim_n = 10;
    stim[0] = 25; stim[1] = 0; stim[2] = 31; stim[3] = 0; stim[4] = 20;
    stim[5] = 0; stim[6] = 30; stim[7] = 0; stim[8] = 29; stim[9] = 0;
    run_stream("R7");
    ped = '0; cut = '0;
  endtask

  task automatic t_index_clamp();
    shift = 4'd0;
    flush();
    stim_n = 6;
    stim[0] = 62; stim[1] = 0; stim[2] = 63; stim[3] = 0; stim[4] = 64; stim[5] = 0;
    run_stream("R8");
    set_coefs(15, 15, 15, 15, 15);
    flush();
    stim_n = 3; stim[0] = 1023; stim[1] = 1023; stim[2] = 0;
    run_stream("R8");
  endtask

  task automatic t_sel_ignored();
    set_coefs(1, 0, 0, 0, 0);
    set_coef(5, 15); set_coef(6, 15); set_coef(7, 15);
    shift = 4'd0;
    flush();
    stim_n = 4; stim[0] = 0; stim[1] = 40; stim[2] = 0; stim[3] = 0;
    run_stream("R9");
  endtask

  task automatic t_latency();
    int cnt;
    set_coefs(1, 0, 0, 0, 0);
    shift = 4'd0;
    flush();
    sample = 10'd50;
    tick();
    sample = '0;
    cnt = 0;
    while (!peak && cnt < 10) begin
      tick();
      cnt++;
    end
    check(cnt == 4, "R4", "edges from capture to peak_o", cnt, 4);
    check(energy == 8'(lut_m[50]), "R6", "energy on strobe", int'(energy), lut_m[50]);
    tick();
    check(peak == 1'b0 && energy == 8'd0, "R6", "energy after strobe", int'(energy), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) c_m[k] = 0;
    for (int a = 0; a < 64; a++) lut_m[a] = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_lut_load();
    t_filter_shape();
    t_two_pulses();
    t_plateau();
    t_alternate();
    t_ped_cut();
    t_index_clamp();
    t_sel_ignored();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule